// File: doc/BRIEF.md
# Crystal Oscillator Startup Timer

This block decides when a freshly enabled crystal oscillator may be trusted. Software performs one write that sets the oscillator on-bit and loads an 8-bit startup count. The block then counts that value down. Each step of the count takes eight cycles of the slow reference clock. When the count is exhausted, the block raises a "main clock stable" flag. An interrupt line follows the flag whenever the interrupt mask bit is set.

Any write that clears the on-bit drops the flag at that write's clock edge. Any write that sets the on-bit and loads a new count also clears the flag, and it restarts the whole delay from the beginning. This includes a write made in the middle of a countdown.

In bypass mode an external clock is used in place of the crystal. Software sets the bypass bit and leaves the on-bit clear. The block then asserts a clock-select output and keeps the oscillator powered down. The whole block runs on the slow clock. Every pin is a plain control or status signal, so no handshake applies.

Top module: `osc_startup_timer`

## Requirements
- R1: After reset, clk_stable, irq, osc_en and ext_clk_sel are all 0, and the interrupt mask is 0.
- R2: A write with wr_osc_on=1 and wr_count=N makes clk_stable rise exactly 8*(N+1) clock edges after the write edge. Before that edge it stays 0.
- R3: A startup count of 0 sets clk_stable on the first divided tick, which is 8 edges after the write. The count does not wrap, and the flag does not fall again afterwards.
- R4: A write with wr_osc_on=0 makes clk_stable 0 from the write edge onward. This holds whether a countdown was running or the flag was already set. No later rise occurs until another enabling write.
- R5: An enabling write made while clk_stable is 1 clears it on the write edge and starts a new full delay.
- R6: An enabling write during a running countdown reloads the count and restarts the divide-by-8 prescaler. The delay is then measured from the new write alone.
- R7: irq is a level equal to clk_stable AND the mask bit. The mask bit is written through mask_stb/mask_d and can be changed at any time.
- R8: osc_en equals the on-bit from the most recent write.
- R9: ext_clk_sel is 1 exactly when the last write had wr_bypass=1 and wr_osc_on=0. While the oscillator stays disabled, clk_stable stays 0.
- R10: The largest count, 255, gives a delay of 2048 edges.
- R11: Once set, clk_stable holds until the next write on wr_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Strobe for a control write (on-bit, bypass, count) |
| wr_osc_on | input | 1 | Oscillator on-bit written by the strobe |
| wr_bypass | input | 1 | Bypass bit written by the strobe |
| wr_count | input | 8 | Startup count written by the strobe |
| mask_stb | input | 1 | Strobe for an interrupt mask write |
| mask_d | input | 1 | Interrupt mask value |
| clk_stable | output | 1 | Main clock stable flag |
| irq | output | 1 | Level interrupt, flag AND mask |
| osc_en | output | 1 | Oscillator power enable |
| ext_clk_sel | output | 1 | Selects the external clock in bypass mode |

## Verification
The bench compares the edge on which the flag rises against the edge that 8*(N+1) predicts. This catches a prescaler that is off by one, and it also catches a counter that stops at 1 instead of running through 0. A count of zero is driven and then held for a long time. A counter that wrapped to 255 would either miss the eight-edge rise or drop the flag later.

Rewrites in mid-countdown are checked against a timing that starts at the new write. A design that kept the old prescaler phase, or ignored the reload, would rise on the wrong edge. Disables during a countdown must be followed by silence on the flag. A design that let the count run on would raise it anyway.

// File: rtl/osc_startup_pkg.sv
package osc_startup_pkg;
  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_COUNT  = 2'd1,
    PH_STABLE = 2'd2
  } osc_phase_e;
endpackage

// File: rtl/osc_mode_regs.sv
module osc_mode_regs (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic wr_osc_on,
  input  logic wr_bypass,
  input  logic mask_stb,
  input  logic mask_d,
  input  logic stable,
  output logic osc_en,
  output logic ext_clk_sel,
  output logic irq
);
  logic on_q, byp_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      byp_q <= 1'b0;
    end else if (wr_stb) begin
      on_q  <= wr_osc_on;
      byp_q <= wr_bypass;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           mask_q <= 1'b0;
    else if (mask_stb) mask_q <= mask_d;
  end

  assign osc_en      = on_q;
  assign ext_clk_sel = byp_q & ~on_q;
  assign irq         = stable & mask_q;
endmodule

// File: rtl/osc_tick_div.sv
module osc_tick_div #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  logic [DIV_LOG2-1:0] phase_cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) phase_cnt <= '0;
    else if (run)       phase_cnt <= phase_cnt + 1'b1;
  end

  assign tick = run & (phase_cnt == {DIV_LOG2{1'b1}});
endmodule

// File: rtl/osc_startup_cnt.sv
module osc_startup_cnt
  import osc_startup_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               kill,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               tick,
  output logic               counting,
  output logic               stable
);
  osc_phase_e         phase_q;
  logic [COUNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_OFF;
      remain_q <= '0;
    end else if (kill) begin
      phase_q  <= PH_OFF;
    end else if (load) begin
      phase_q  <= PH_COUNT;
      remain_q <= load_val;
    end else if (phase_q == PH_COUNT && tick) begin
      if (remain_q == '0) phase_q  <= PH_STABLE;
      else                remain_q <= remain_q - 1'b1;
    end
  end

  assign counting = (phase_q == PH_COUNT);
  assign stable   = (phase_q == PH_STABLE);
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer #(
  parameter int COUNT_W  = 8,
  parameter int DIV_LOG2 = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic               wr_osc_on,
  input  logic               wr_bypass,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic               mask_stb,
  input  logic               mask_d,
  output logic               clk_stable,
  output logic               irq,
  output logic               osc_en,
  output logic               ext_clk_sel
);
  logic load_req, kill_req, presc_tick, counting;

  assign load_req = wr_stb &  wr_osc_on;
  assign kill_req = wr_stb & ~wr_osc_on;

  osc_mode_regs u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_osc_on(wr_osc_on),
    .wr_bypass(wr_bypass), .mask_stb(mask_stb), .mask_d(mask_d),
    .stable(clk_stable), .osc_en(osc_en), .ext_clk_sel(ext_clk_sel), .irq(irq)
  );

  osc_tick_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst(rst), .restart(load_req), .run(counting), .tick(presc_tick)
  );

  osc_startup_cnt #(.COUNT_W(COUNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_req), .kill(kill_req),
    .load_val(wr_count), .tick(presc_tick), .counting(counting), .stable(clk_stable)
  );
endmodule

// File: rtl/osc_startup_chk.sv
module osc_startup_chk #(
  parameter int DIV_LOG2 = 3
) (
  input logic clk,
  input logic rst,
  input logic wr_stb,
  input logic wr_osc_on,
  input logic clk_stable,
  input logic irq,
  input logic osc_en,
  input logic ext_clk_sel,
  input logic presc_tick
);
  logic [15:0] since_load;

  always_ff @(posedge clk) begin
    if (rst || (wr_stb && wr_osc_on)) since_load <= '0;
    else if (since_load != 16'hFFFF)  since_load <= since_load + 1'b1;
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) irq |-> clk_stable); // R7
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst) (wr_stb && !wr_osc_on) |=> !clk_stable); // R4
  AST_REWRITE_DROPS: assert property (@(posedge clk) disable iff (rst) (wr_stb && wr_osc_on) |=> !clk_stable); // R5
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst) (clk_stable && !wr_stb) |=> clk_stable); // R11
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst) $rose(clk_stable) |-> $past(presc_tick)); // R2
  AST_MIN_DELAY: assert property (@(posedge clk) disable iff (rst) $rose(clk_stable) |-> (since_load >= 16'(1 << DIV_LOG2))); // R3
  AST_BYPASS_OSC_OFF: assert property (@(posedge clk) disable iff (rst) ext_clk_sel |-> !osc_en); // R9
  AST_FLAG_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst) clk_stable |-> osc_en); // R8
endmodule

bind osc_startup_timer osc_startup_chk #(.DIV_LOG2(DIV_LOG2)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_osc_on(wr_osc_on),
  .clk_stable(clk_stable), .irq(irq), .osc_en(osc_en),
  .ext_clk_sel(ext_clk_sel), .presc_tick(presc_tick)
);

// File: tb/sim_osc_startup_timer.sv
module sim_osc_startup_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0, wr_osc_on = 1'b0, wr_bypass = 1'b0;
  logic [7:0] wr_count = 8'd0;
  logic mask_stb = 1'b0, mask_d = 1'b0;
  logic clk_stable, irq, osc_en, ext_clk_sel;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_cyc[$];
  string exp_tag[$];
  logic prev_stable = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  osc_startup_timer u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_osc_on(wr_osc_on),
    .wr_bypass(wr_bypass), .wr_count(wr_count), .mask_stb(mask_stb),
    .mask_d(mask_d), .clk_stable(clk_stable), .irq(irq), .osc_en(osc_en),
    .ext_clk_sel(ext_clk_sel)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: one control write; pending expectations are superseded
  task automatic ctl_write(input logic on, input logic byp, input int n, input string tag);
    @(negedge clk);
    wr_stb = 1'b1; wr_osc_on = on; wr_bypass = byp; wr_count = 8'(n);
    exp_cyc.delete(); exp_tag.delete();
    if (on) begin
      exp_cyc.push_back(cyc + 1 + 8 * (n + 1));
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic set_mask(input logic m);
    @(negedge clk);
    mask_stb = 1'b1; mask_d = m;
    @(negedge clk);
    mask_stb = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && exp_cyc.size() > 0; i++) @(negedge clk);
    check("R2 pending rise seen", exp_cyc.size(), 0);
  endtask

  // monitor: sampled 1 time unit after the edge, pops the scoreboard on each rise
  always @(posedge clk) begin
    #1;
    if (!rst) begin
      if (clk_stable && !prev_stable) begin
        if (exp_cyc.size() == 0) begin
          check("R4 unexpected rise", 1, 0);
        end else begin
          string t;
          int e;
          t = exp_tag.pop_front();
          e = exp_cyc.pop_front();
          check(t, cyc, e);
        end
      end
      prev_stable = clk_stable;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    wait_cycles(4);
    rst = 1'b0;
    @(negedge clk);
    check("R1 stable", clk_stable, 0);
    check("R1 irq", irq, 0);
    check("R1 osc_en", osc_en, 0);
    check("R1 ext_clk_sel", ext_clk_sel, 0);

    set_mask(1'b1);
    check("R1 mask only, irq", irq, 0);

    // basic countdown
    ctl_write(1'b1, 1'b0, 3, "R2 count 3");
    check("R8 osc_en after enable", osc_en, 1);
    check("R2 flag low after write", clk_stable, 0);
    wait_drain();
    check("R7 irq with mask set", irq, 1);
    set_mask(1'b0);
    check("R7 irq with mask clear", irq, 0);
    set_mask(1'b1);
    check("R7 irq mask restored", irq, 1);
    wait_cycles(20);
    check("R11 flag held", clk_stable, 1);

    // re-enable while stable, count 0
    ctl_write(1'b1, 1'b0, 0, "R3 count 0");
    check("R5 flag cleared by rewrite", clk_stable, 0);
    wait_drain();
    wait_cycles(40);
    check("R3 no underflow, flag held", clk_stable, 1);

    // rewrite mid-countdown
    ctl_write(1'b1, 1'b0, 10, "R6 superseded");
    wait_cycles(41);
    ctl_write(1'b1, 1'b0, 1, "R6 reload count 1");
    wait_drain();

    // disable while stable
    ctl_write(1'b0, 1'b0, 0, "R4");
    check("R4 flag dropped", clk_stable, 0);
    check("R8 osc_en after disable", osc_en, 0);
    check("R7 irq after disable", irq, 0);
    wait_cycles(50);
    check("R4 flag stays low", clk_stable, 0);

    // disable during countdown
    ctl_write(1'b1, 1'b0, 4, "R4 aborted");
    wait_cycles(13);
    ctl_write(1'b0, 1'b0, 4, "R4");
    wait_cycles(80);
    check("R4 aborted countdown silent", clk_stable, 0);

    // bypass
    ctl_write(1'b0, 1'b1, 0, "R9");
    check("R9 ext_clk_sel in bypass", ext_clk_sel, 1);
    check("R9 osc_en in bypass", osc_en, 0);
    wait_cycles(30);
    check("R9 flag low in bypass", clk_stable, 0);
    ctl_write(1'b1, 1'b1, 2, "R9 bypass+on count 2");
    check("R9 ext_clk_sel with on-bit", ext_clk_sel, 0);
    wait_drain();

    // full scale
    ctl_write(1'b1, 1'b0, 255, "R10 count 255");
    wait_cycles(2000);
    check("R10 still counting", clk_stable, 0);
    wait_drain();
    check("R10 flag set", clk_stable, 1);

    wait_cycles(5);
    summary();
  end
endmodule